// File: doc/BRIEF.md
# Flagless 8-bit Load-Store Processor Core

This block is a small accumulator-style processor with 8-bit registers, a 16-bit address space and no condition flags or interrupts. Every memory address is built as a page byte above a low byte. The page comes from an immediate or from the BH register. The low byte comes from an immediate or from B. A full 16-bit address can also be given as two immediate bytes. Conditional branches test A for zero directly.

The core fetches variable-length instructions from one byte-wide synchronous memory port. A read returns its data one cycle after the address is presented. The same port carries data loads and stores. Instructions run through a short sequence of fetch, decode, immediate, address and execute steps, and steps that an instruction does not need are skipped. The `halted` output lets a test environment stop a run once the program reaches its end marker.

Top module: `flagless_cpu8`

## Requirements
- R1: While reset is held and in the first cycle after it, the program counter is 0x0000. The first fetch address is 0x0000, write enable is low and `halted` is low.
- R2: An instruction is one opcode byte followed by zero, one or two immediate bytes, and a two-byte address is stored low byte first. The opcode address is driven in the first cycle and the next sequential byte address in the second. There is one more sequential cycle for each immediate byte after the first. Then comes one address/execute cycle, plus one extra cycle for a load from memory. Whenever no data access is made, the address bus shows the program counter, and the counter ends one past the last byte of the instruction.
- R3: The three data address forms are: absolute `{imm2, imm1}`; paged `{BH, imm1}`; indirect `{BH, B}`.
- R4: Loads follow this map. Opcodes 0..3 load A from immediate, absolute, paged and indirect sources. Opcodes 4..7 do the same for B. Opcode 8 loads BH from an immediate and opcode 9 loads BH through the paged form. A load from memory captures the byte read one cycle after the data address.
- R5: Stores follow this map. Opcodes 10..12 store A through the absolute, paged and indirect forms. Opcodes 13..15 do the same for B. Opcode 16 stores BH through the paged form. Write enable is high for exactly one cycle, with the source register on the write data bus, and no other instruction writes.
- R6: Exchanges swap a register pair in one cycle: opcode 17 swaps A and B, 18 swaps A and BH, and 19 swaps B and BH.
- R7: ALU opcodes write A modulo 256 and record nothing else: 20 NOT A, 21 A AND B, 22 A OR B, 23 A XOR B, 24 A+1, 25 A-1, 26 A+B, 27 A-B.
- R8: Opcodes 28..30 branch when A is zero and 31..33 branch when A is nonzero, each group using the absolute, paged and indirect forms in that order. Opcodes 34..36 jump unconditionally with the same forms. A taken branch loads the target into the program counter, and an untaken one continues with the next instruction.
- R9: Opcode 0xFF raises `halted` from the cycle after its decode onward. From then on there are no writes and the address bus is frozen.
- R10: Opcodes 37..254 are one-byte no-ops that leave all registers and memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Byte address for fetch, load or store |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| mem_we | output | 1 | Store strobe |
| halted | output | 1 | High once the halt opcode has executed |

## Verification
On every cycle, the assertions cover several behaviours. A store strobe never lasts more than one cycle. A halted core stays halted with a frozen, write-free bus. A fetch cycle always advances the program counter by one into decode. An A/B exchange swaps both values in one edge. Increment wraps, and the zero test either loads the branch target or leaves the counter alone. Other behaviours show only in the bench's programs, which compare the whole bus against an instruction-level model on every clock and check the final memory image. These are the correct data address per form, the value captured by each load, the results of all eight ALU operations at their wrap points, and the continuation after taken and untaken branches in every form.

// File: rtl/flagless_cpu8.sv
`timescale 1ns/1ps
module flagless_cpu8 #(
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter logic [7:0]  HALT_OP  = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        mem_we,
  output logic        halted
);
  typedef enum logic [2:0] {S_FETCH, S_DEC, S_IMM1, S_IMM2, S_ADDR, S_EXEC, S_HALT} state_t;
  typedef enum logic [2:0] {C_NOP, C_LD, C_ST, C_XCH, C_ALU, C_BR} cls_t;
  localparam logic [1:0] M_IMM = 2'd0, M_ABS = 2'd1, M_PG = 2'd2, M_IND = 2'd3;

  state_t      st;
  logic [15:0] pc, ea;
  logic [7:0]  ra, rb, rh, ir, lo, hi, t, src, alu;
  logic [1:0]  rsel, am, cond, nimm;
  logic [2:0]  aop;
  cls_t        cls;
  logic        taken;

  wire [7:0] op = (st == S_DEC) ? mem_rdata : ir;

  always_comb begin
    cls = C_NOP; rsel = 2'd0; am = M_IMM; cond = 2'd0; aop = 3'd0; t = 8'd0;
    if (op < 8'd8) begin
      cls = C_LD; rsel = {1'b0, op[2]}; am = op[1:0];
    end else if (op < 8'd10) begin
      cls = C_LD; rsel = 2'd2; am = op[0] ? M_PG : M_IMM;
    end else if (op < 8'd16) begin
      cls = C_ST; t = op - 8'd10; rsel = (t >= 8'd3) ? 2'd1 : 2'd0;
      am = 2'(t % 8'd3) + 2'd1;
    end else if (op == 8'd16) begin
      cls = C_ST; rsel = 2'd2; am = M_PG;
    end else if (op < 8'd20) begin
      cls = C_XCH; rsel = 2'(op - 8'd17);
    end else if (op < 8'd28) begin
      cls = C_ALU; aop = 3'(op - 8'd20);
    end else if (op < 8'd37) begin
      cls = C_BR; t = op - 8'd28; cond = 2'(t / 8'd3);
      am = 2'(t % 8'd3) + 2'd1;
    end
  end

  always_comb begin
    nimm = 2'd0;
    if (cls == C_LD || cls == C_ST || cls == C_BR)
      nimm = (am == M_ABS) ? 2'd2 : (am == M_IND) ? 2'd0 : 2'd1;
  end

  assign ea  = (am == M_ABS) ? {hi, lo} : (am == M_PG) ? {rh, lo} : {rh, rb};
  assign src = (rsel == 2'd0) ? ra : (rsel == 2'd1) ? rb : rh;

  always_comb begin
    case (aop)
      3'd0: alu = ~ra;
      3'd1: alu = ra & rb;
      3'd2: alu = ra | rb;
      3'd3: alu = ra ^ rb;
      3'd4: alu = ra + 8'd1;
      3'd5: alu = ra - 8'd1;
      3'd6: alu = ra + rb;
      default: alu = ra - rb;
    endcase
  end

  assign taken     = (cond == 2'd2) || (cond == 2'd0 && ra == 8'd0) || (cond == 2'd1 && ra != 8'd0);
  assign mem_we    = (st == S_ADDR) && (cls == C_ST);
  assign mem_addr  = ((st == S_ADDR) && (cls == C_ST || (cls == C_LD && am != M_IMM))) ? ea : pc;
  assign mem_wdata = src;
  assign halted    = (st == S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_FETCH; pc <= RESET_PC;
      ra <= '0; rb <= '0; rh <= '0; ir <= '0; lo <= '0; hi <= '0;
    end else begin
      case (st)
        S_FETCH: begin pc <= pc + 16'd1; st <= S_DEC; end
        S_DEC: begin
          ir <= mem_rdata;
          if (mem_rdata == HALT_OP) st <= S_HALT;
          else if (nimm != 2'd0) begin pc <= pc + 16'd1; st <= S_IMM1; end
          else st <= S_ADDR;
        end
        S_IMM1: begin
          lo <= mem_rdata;
          if (nimm == 2'd2) begin pc <= pc + 16'd1; st <= S_IMM2; end
          else st <= S_ADDR;
        end
        S_IMM2: begin hi <= mem_rdata; st <= S_ADDR; end
        S_ADDR: begin
          st <= S_FETCH;
          case (cls)
            C_LD:
              if (am == M_IMM) begin
                case (rsel)
                  2'd0: ra <= lo;
                  2'd1: rb <= lo;
                  default: rh <= lo;
                endcase
              end else st <= S_EXEC;
            C_XCH:
              case (rsel)
                2'd0: begin ra <= rb; rb <= ra; end
                2'd1: begin ra <= rh; rh <= ra; end
                default: begin rb <= rh; rh <= rb; end
              endcase
            C_ALU: ra <= alu;
            C_BR: if (taken) pc <= ea;
            default: ;
          endcase
        end
        S_EXEC: begin
          case (rsel)
            2'd0: ra <= mem_rdata;
            2'd1: rb <= mem_rdata;
            default: rh <= mem_rdata;
          endcase
          st <= S_FETCH;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  a_r9_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we && $stable(mem_addr)));
  a_r2_fetch_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |=> (st == S_DEC && pc == $past(pc) + 16'd1));
  a_r6_swap_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && cls == C_XCH && rsel == 2'd0) |=> (ra == $past(rb) && rb == $past(ra)));
  a_r7_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && cls == C_ALU && aop == 3'd4) |=> (ra == $past(ra) + 8'd1));
  a_r8_zero_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && cls == C_BR && cond == 2'd0 && ra == 8'd0) |=> (pc == $past(ea)));
  a_r8_nonzero_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && cls == C_BR && cond == 2'd1 && ra == 8'd0) |=> (pc == $past(pc)));
endmodule

// File: tb/sim_flagless_cpu8.sv
`timescale 1ns/1ps
module sim_flagless_cpu8;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, rdata_q;
  logic        mem_we, halted;

  flagless_cpu8 u0 (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
                    .mem_rdata(rdata_q), .mem_we(mem_we), .halted(halted));

  logic [7:0] mem [0:2047];
  logic [7:0] mm  [0:2047];
  always @(posedge clk) begin
    rdata_q <= mem[mem_addr[10:0]];
    if (mem_we) mem[mem_addr[10:0]] = mem_wdata;
  end

  typedef struct { logic [15:0] a; bit we; logic [7:0] d; bit h; string tag; } cyc_t;
  cyc_t q[$];
  logic [7:0]  ma, mb, mh;
  logic [15:0] mpc, hpc;
  bit          mhalt;
  int          nchk = 0, nfail = 0, wp = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void push(logic [15:0] a, bit w, logic [7:0] d, bit h, string tag);
    cyc_t e;
    e.a = a; e.we = w; e.d = d; e.h = h; e.tag = tag;
    q.push_back(e);
  endfunction

  function automatic logic [7:0] rd(logic [15:0] a);
    return mm[a[10:0]];
  endfunction

  // 1 immediate, 2 absolute, 3 paged, 4 indirect, 0 none
  function automatic int fm(logic [7:0] op);
    if (op < 8) return 1 + int'(op[1:0]);
    if (op == 8) return 1;
    if (op == 9 || op == 16) return 3;
    if (op >= 10 && op <= 15) return 2 + (int'(op) - 10) % 3;
    if (op >= 28 && op <= 36) return 2 + (int'(op) - 28) % 3;
    return 0;
  endfunction

  function automatic void mstep();
    logic [15:0] p, ea, nx;
    logic [7:0]  op, b1, b2, v;
    int f, n, k;
    bit tk;
    p = mpc; op = rd(p); b1 = rd(p + 16'd1); b2 = rd(p + 16'd2);
    push(p, 0, 0, 0, "R2");
    push(p + 16'd1, 0, 0, 0, "R2");
    if (op == 8'hFF) begin mhalt = 1; hpc = p + 16'd1; return; end
    f = fm(op);
    n = (f == 1 || f == 3) ? 1 : (f == 2) ? 2 : 0;
    if (n >= 1) push(p + 16'd2, 0, 0, 0, "R2");
    if (n == 2) push(p + 16'd3, 0, 0, 0, "R2");
    nx = p + 16'd1 + 16'(n);
    ea = (f == 2) ? {b2, b1} : (f == 3) ? {mh, b1} : {mh, mb};
    if (op <= 9) begin
      if (f == 1) begin v = b1; push(nx, 0, 0, 0, "R4"); end
      else begin v = rd(ea); push(ea, 0, 0, 0, "R3"); push(nx, 0, 0, 0, "R4"); end
      if (op < 4) ma = v; else if (op < 8) mb = v; else mh = v;
    end else if (op <= 16) begin
      v = (op <= 12) ? ma : (op <= 15) ? mb : mh;
      push(ea, 1, v, 0, "R5");
      mm[ea[10:0]] = v;
    end else if (op <= 19) begin
      if (op == 17) begin v = ma; ma = mb; mb = v; end
      else if (op == 18) begin v = ma; ma = mh; mh = v; end
      else begin v = mb; mb = mh; mh = v; end
      push(nx, 0, 0, 0, "R6");
    end else if (op <= 27) begin
      case (op)
        8'd20: ma = ~ma;
        8'd21: ma = ma & mb;
        8'd22: ma = ma | mb;
        8'd23: ma = ma ^ mb;
        8'd24: ma = ma + 8'd1;
        8'd25: ma = ma - 8'd1;
        8'd26: ma = ma + mb;
        default: ma = ma - mb;
      endcase
      push(nx, 0, 0, 0, "R7");
    end else if (op <= 36) begin
      k = (int'(op) - 28) / 3;
      tk = (k == 2) || (k == 0 && ma == 0) || (k == 1 && ma != 0);
      push(nx, 0, 0, 0, "R8");
      if (tk) nx = ea;
    end else begin
      push(nx, 0, 0, 0, "R10");
    end
    mpc = nx;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) begin mem[i] = 8'h00; mm[i] = 8'h00; end
    wp = 0;
  endtask
  task automatic org(int a); wp = a; endtask
  task automatic e1(logic [7:0] x); mem[wp] = x; mm[wp] = x; wp++; endtask
  task automatic e2(logic [7:0] x, logic [7:0] y); e1(x); e1(y); endtask
  task automatic e3(logic [7:0] x, logic [7:0] y, logic [7:0] z); e1(x); e1(y); e1(z); endtask
  task automatic poke(int a, logic [7:0] x); mem[a] = x; mm[a] = x; endtask
  task automatic chk_mem(int a, logic [7:0] exp, string req);
    chk(mem[a] === exp, req, $sformatf("mem[%h]", a), 32'(mem[a]), 32'(exp));
  endtask

  task automatic run_prog();
    int cyc, hcnt, bad, first;
    cyc_t e;
    bit ok;
    rst_n = 1'b0; mpc = 16'h0000; ma = 0; mb = 0; mh = 0; mhalt = 0; q.delete();
    repeat (3) @(negedge clk);
    chk(mem_addr == 16'h0000 && !mem_we && !halted, "R1", "reset bus",
        {14'd0, mem_we, halted, mem_addr}, 32'd0);
    rst_n = 1'b1; hcnt = 0; cyc = 0;
    while (hcnt < 3) begin
      if (q.size() == 0) begin
        if (mhalt) push(hpc, 0, 0, 1, "R9"); else mstep();
      end
      e = q.pop_front();
      ok = (mem_addr == e.a) && (mem_we == e.we) && (halted == e.h) && (!e.we || mem_wdata == e.d);
      chk(ok, e.tag, "bus {halt,we,wdata,addr}",
          {6'd0, halted, mem_we, mem_we ? mem_wdata : 8'h00, mem_addr},
          {6'd0, e.h, e.we, e.we ? e.d : 8'h00, e.a});
      if (e.h) hcnt++;
      cyc++;
      if (cyc > 5000) begin chk(0, "R2", "watchdog expired", 32'(cyc), 32'd5000); break; end
      @(negedge clk);
    end
    bad = 0; first = 0;
    for (int i = 0; i < 2048; i++)
      if (mem[i] !== mm[i]) begin if (bad == 0) first = i; bad++; end
    chk(bad == 0, "R5", $sformatf("memory image, first mismatch at %h", first),
        32'(mem[first]), 32'(mm[first]));
  endtask

  initial begin
    // Program 1: loads, stores, exchanges (R3 R4 R5 R6)
    clear_mem();
    poke('h520, 8'h3C); poke('h311, 8'h77); poke('h344, 8'h5A);
    poke('h312, 8'h04); poke('h410, 8'hAB); poke('h445, 8'h99);
    e2(0, 8'h11); e2(8, 8'h03); e3(5, 8'h20, 8'h05); e2(2, 8'h11);
    e3(10, 8'h00, 8'h06); e2(14, 8'h01); e2(4, 8'h44); e1(3);
    e2(4, 8'h45); e1(12); e2(9, 8'h12); e2(16, 8'h02);
    e3(1, 8'h11, 8'h03); e2(6, 8'h10); e3(13, 8'h01, 8'h06);
    e2(4, 8'h45); e1(7); e1(15); e2(11, 8'h03);
    e1(17); e3(10, 8'h10, 8'h06); e3(13, 8'h11, 8'h06);
    e1(19); e3(13, 8'h12, 8'h06); e1(18); e3(10, 8'h13, 8'h06);
    e1(8'hFF);
    run_prog();
    chk_mem('h600, 8'h77, "R4"); chk_mem('h301, 8'h3C, "R3");
    chk_mem('h345, 8'h5A, "R3"); chk_mem('h402, 8'h04, "R5");
    chk_mem('h601, 8'hAB, "R4"); chk_mem('h499, 8'h99, "R5");
    chk_mem('h403, 8'h77, "R5"); chk_mem('h610, 8'h99, "R6");
    chk_mem('h611, 8'h77, "R6"); chk_mem('h612, 8'h04, "R6");
    chk_mem('h613, 8'h77, "R6");

    // Program 2: ALU wraparound and a no-op (R7 R10)
    clear_mem();
    e2(8, 8'h06); e2(0, 8'hFF); e1(24); e2(11, 8'h00);
    e1(25); e2(11, 8'h01); e2(4, 8'h5C);
    e2(0, 8'hC5); e1(21); e2(11, 8'h02);
    e2(0, 8'hC5); e1(22); e2(11, 8'h03);
    e2(0, 8'hC5); e1(23); e2(11, 8'h04);
    e2(0, 8'hC5); e1(20); e2(11, 8'h05);
    e2(0, 8'hC5); e1(26); e2(11, 8'h06);
    e2(0, 8'h5C); e2(4, 8'hC5); e1(27); e2(11, 8'h07);
    e1(8'h80); e2(11, 8'h08); e1(8'hFF);
    run_prog();
    chk_mem('h600, 8'h00, "R7"); chk_mem('h601, 8'hFF, "R7");
    chk_mem('h602, 8'h44, "R7"); chk_mem('h603, 8'hDD, "R7");
    chk_mem('h604, 8'h99, "R7"); chk_mem('h605, 8'h3A, "R7");
    chk_mem('h606, 8'h21, "R7"); chk_mem('h607, 8'h97, "R7");
    chk_mem('h608, 8'h97, "R10");

    // Program 3: branches and jumps in every form (R8)
    clear_mem();
    e2(8, 8'h07); e2(0, 8'h00); e3(28, 8'h00, 8'h01); e1(8'hFF);
    org('h100); e2(0, 8'h01); e2(11, 8'h00); e2(29, 8'h50);
    e2(0, 8'h02); e2(11, 8'h01); e3(31, 8'h00, 8'h02); e1(8'hFF);
    org('h200); e2(0, 8'h03); e2(11, 8'h02); e2(0, 8'h00); e3(31, 8'h00, 8'h07);
    e2(0, 8'h05); e2(8, 8'h03); e2(32, 8'h00); e1(8'hFF);
    org('h300); e2(8, 8'h07); e2(0, 8'h04); e2(11, 8'h03);
    e2(0, 8'h00); e2(8, 8'h04); e2(29, 8'h00); e1(8'hFF);
    org('h400); e2(8, 8'h07); e2(0, 8'h05); e2(11, 8'h04);
    e2(0, 8'h00); e2(8, 8'h05); e2(4, 8'h10); e1(30); e1(8'hFF);
    org('h510); e2(8, 8'h07); e2(0, 8'h06); e2(11, 8'h05);
    e2(8, 8'h05); e2(4, 8'h40); e1(33); e1(8'hFF);
    org('h540); e1(30); e3(34, 8'h00, 8'h06); e1(8'hFF);
    org('h600); e2(8, 8'h07); e2(0, 8'h07); e2(11, 8'h06);
    e2(8, 8'h06); e2(35, 8'h20); e1(8'hFF);
    org('h620); e2(4, 8'h40); e1(36); e1(8'hFF);
    org('h640); e2(8, 8'h07); e2(0, 8'h08); e2(11, 8'h07); e1(8'hFF);
    run_prog();
    for (int i = 0; i < 8; i++) chk_mem('h700 + i, 8'(i + 1), "R8");

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule